// File: doc/BRIEF.md
# Scan-Chain State Compare and Repair Controller for Triplicated Logic

This controller sits beside three identical copies of a logic block. Each copy exposes a test scan chain of `CHAIN_LEN` flip-flops through a shared scan-enable, its own scan-in and its own scan-out. On a start request the controller shifts all three chains together for one full chain length. Each chain is fed back into itself, so its contents come back unchanged. While the chains shift, the controller compares the three serial streams in pairs. It counts the differing bits separately for pair 1/2, pair 1/3 and pair 2/3.

When the comparison ends, the controller raises a one-cycle done pulse and samples a faulty-module mask from outside logic. That logic decides the fault location from the three counts. If the mask names one or two faulty copies, a repair pass follows. Each faulty copy is reloaded from the scan-out of the lowest-numbered healthy copy, while every healthy copy keeps recirculating. The streams are compared again during this pass, and each mismatch now lowers the matching counter. A second done pulse closes the repair pass. It carries a pass flag that is high only when all three counters have returned to zero. A nonzero counter at that point means a new upset struck during the repair.

Top module: `tmr_scan_repair`

## Requirements
- R1: A start pulse in the idle state begins a compare pass. Scan-enable is high for exactly `CHAIN_LEN` clock cycles, and each module's scan-in is driven from its own scan-out. All three chains therefore hold their original contents afterwards. A start pulse while a pass is running is ignored.
- R2: The counters `cnt_12`, `cnt_13` and `cnt_23` are cleared when a compare pass starts. During the pass, each counter rises by one on every shift cycle in which the scan-outs of its two modules differ.
- R3: The counters saturate. An increment at the all-ones value leaves it unchanged, and a decrement at zero leaves it at zero. With the default `CNT_W` of 4 the ceiling is 15.
- R4: After the last compare shift, `done` is high for one cycle, with `rep_busy` low. The counters hold their final compare values in that cycle, and `fault_mask` is sampled in that cycle. In the mask, bit 0 marks module 1, bit 1 marks module 2 and bit 2 marks module 3 as faulty.
- R5: If the sampled mask has one or two bits set, a repair pass of exactly `CHAIN_LEN` shift cycles follows at once. In it, each healthy module recirculates, and each faulty module's scan-in takes the scan-out of the lowest-numbered healthy module. A mask with zero or three bits set returns the block to idle without a repair pass and without a second done pulse.
- R6: During the repair pass, each counter falls by one on every shift cycle in which the scan-outs of its two modules differ.
- R7: After the last repair shift, `done` is high for one cycle. `repair_ok` is high in that cycle only if all three counters read zero, and it is low at all other times.
- R8: After reset, scan-enable, `cmp_busy`, `rep_busy`, `done` and `repair_ok` are low and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a compare pass when idle |
| fault_mask | input | 3 | Faulty-module flags, bit i for module i+1, sampled in the compare done cycle |
| scan_out | input | 3 | Serial outputs of the three module scan chains |
| scan_en | output | 1 | Shared scan-enable for the three chains |
| scan_in | output | 3 | Serial inputs to the three module scan chains |
| cmp_busy | output | 1 | Compare pass in progress |
| rep_busy | output | 1 | Repair pass in progress |
| done | output | 1 | One-cycle pulse at the end of each pass |
| repair_ok | output | 1 | High in the repair done cycle when all counters are zero |
| cnt_12 | output | CNT_W | Mismatch count for modules 1 and 2 |
| cnt_13 | output | CNT_W | Mismatch count for modules 1 and 3 |
| cnt_23 | output | CNT_W | Mismatch count for modules 2 and 3 |

## Verification
The properties assume that the three chains shift only on `scan_en` and present a new bit on every shifted cycle. They also assume that `fault_mask` stays steady from the start pulse through the compare done cycle. The bench models each chain as a shift register that meets these conditions and holds the mask constant for a whole pass. It places error patterns in one or two copies, including overlapping ones and a fully inverted chain that drives the counters into saturation. It also flips one pending bit of a faulty chain during a repair pass, so that one expected mismatch disappears and the pass flag must stay low.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   localparam int unsigned NMOD = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMP,
      ST_LOC,
      ST_REP,
      ST_FIN
   } tsr_state_e;

   // lowest-numbered module not flagged faulty (mask is known to be valid)
   function automatic logic [1:0] first_good(input logic [2:0] fm);
      if (!fm[0]) return 2'd0;
      if (!fm[1]) return 2'd1;
      return 2'd2;
   endfunction

   function automatic logic mask_repairable(input logic [2:0] fm);
      return ($countones(fm) == 1) || ($countones(fm) == 2);
   endfunction

endpackage

// File: rtl/tsr_seq.sv
module tsr_seq
   import tsr_pkg::*;
#(
   parameter int unsigned CHAIN_LEN = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] fault_mask_in,
   output logic       cmp_on,
   output logic       rep_on,
   output logic       loc_on,
   output logic       fin_on,
   output logic       clr_cnt,
   output logic [2:0] rep_mask
);

   localparam int unsigned PH_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(CHAIN_LEN - 1);

   tsr_state_e      state;
   logic [PH_W-1:0] ph;

   assign cmp_on  = (state == ST_CMP);
   assign rep_on  = (state == ST_REP);
   assign loc_on  = (state == ST_LOC);
   assign fin_on  = (state == ST_FIN);
   assign clr_cnt = (state == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ph       <= '0;
         rep_mask <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               ph <= '0;
               if (start) state <= ST_CMP;
            end
            ST_CMP: begin
               if (ph == PH_LAST) begin
                  ph    <= '0;
                  state <= ST_LOC;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_LOC: begin
               ph       <= '0;
               rep_mask <= fault_mask_in;
               state    <= mask_repairable(fault_mask_in) ? ST_REP : ST_IDLE;
            end
            ST_REP: begin
               if (ph == PH_LAST) begin
                  ph    <= '0;
                  state <= ST_FIN;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4
   cmp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmp_on) |-> loc_on);

   // R1
   start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_on && ph != PH_LAST) |=> (cmp_on && !loc_on));

   // R5
   rep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_on && mask_repairable(fault_mask_in)) |=> rep_on);

   // R5
   no_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_on && !mask_repairable(fault_mask_in)) |=> (!rep_on && !cmp_on && !fin_on));

endmodule

// File: rtl/tsr_pair_cnt.sv
module tsr_pair_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end else if (dec && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);

   // R3
   floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !clr && cnt == '0) |=> cnt == '0);

   // R2
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

   // R6
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !clr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/tsr_route.sv
module tsr_route
   import tsr_pkg::*;
(
   input  logic       rep_on,
   input  logic [2:0] rep_mask,
   input  logic [2:0] scan_out,
   output logic [2:0] scan_in
);

   logic [1:0] src;
   assign src = first_good(rep_mask);

   for (genvar m = 0; m < NMOD; m++) begin : g_mod
      always_comb begin
         if (rep_on && rep_mask[m]) scan_in[m] = scan_out[src];
         else                       scan_in[m] = scan_out[m];
      end
   end

endmodule

// File: rtl/tmr_scan_repair.sv
module tmr_scan_repair
   import tsr_pkg::*;
#(
   parameter int unsigned CHAIN_LEN = 16,
   parameter int unsigned CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [2:0]       fault_mask,
   input  logic [2:0]       scan_out,
   output logic             scan_en,
   output logic [2:0]       scan_in,
   output logic             cmp_busy,
   output logic             rep_busy,
   output logic             done,
   output logic             repair_ok,
   output logic [CNT_W-1:0] cnt_12,
   output logic [CNT_W-1:0] cnt_13,
   output logic [CNT_W-1:0] cnt_23
);

   localparam int unsigned NPAIR = 3;
   localparam int PA [NPAIR] = '{0, 0, 1};
   localparam int PB [NPAIR] = '{1, 2, 2};

   if (CHAIN_LEN < 2) begin : g_bad_len
      $error("CHAIN_LEN must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must be in 1..32");
   end

   logic       cmp_on, rep_on, loc_on, fin_on, clr_cnt;
   logic [2:0] rep_mask;
   logic [CNT_W-1:0] cnt [NPAIR];

   tsr_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .fault_mask_in (fault_mask),
      .cmp_on        (cmp_on),
      .rep_on        (rep_on),
      .loc_on        (loc_on),
      .fin_on        (fin_on),
      .clr_cnt       (clr_cnt),
      .rep_mask      (rep_mask)
   );

   tsr_route u_route (
      .rep_on   (rep_on),
      .rep_mask (rep_mask),
      .scan_out (scan_out),
      .scan_in  (scan_in)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic diff;
      assign diff = scan_out[PA[p]] ^ scan_out[PB[p]];
      tsr_pair_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr_cnt),
         .inc   (cmp_on & diff),
         .dec   (rep_on & diff),
         .cnt   (cnt[p])
      );
   end

   assign cnt_12    = cnt[0];
   assign cnt_13    = cnt[1];
   assign cnt_23    = cnt[2];
   assign scan_en   = cmp_on | rep_on;
   assign cmp_busy  = cmp_on;
   assign rep_busy  = rep_on;
   assign done      = loc_on | fin_on;
   assign repair_ok = fin_on && (cnt[0] == '0) && (cnt[1] == '0) && (cnt[2] == '0);

   // R7
   ok_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repair_ok |-> (done && $past(rep_busy)));

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(rep_busy)) |=> (cnt_12 == $past(cnt_12) && cnt_13 == $past(cnt_13) && cnt_23 == $past(cnt_23)));

endmodule

// File: tb/tmr_scan_repair_bench.sv
module tmr_scan_repair_bench;

   localparam int unsigned L     = 16;
   localparam int unsigned CW    = 4;
   localparam int          CMAX  = (1 << CW) - 1;
   localparam logic [L-1:0] GOLD = 16'hA5C3;

   typedef struct {
      bit    is_rep;
      int    c12;
      int    c13;
      int    c23;
      bit    ok;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] fault_mask = 3'b000;
   logic [2:0] scan_out, scan_in;
   logic scan_en, cmp_busy, rep_busy, done, repair_ok;
   logic [CW-1:0] cnt_12, cnt_13, cnt_23;

   logic [2:0][L-1:0] ch;
   logic [2:0][L-1:0] ld_val;
   logic [2:0][L-1:0] inj;
   logic ld = 1'b0;

   int checks = 0;
   int fails  = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   tmr_scan_repair #(.CHAIN_LEN(L), .CNT_W(CW)) u_tmr_scan_repair (
      .clk(clk), .rst_n(rst_n), .start(start), .fault_mask(fault_mask),
      .scan_out(scan_out), .scan_en(scan_en), .scan_in(scan_in),
      .cmp_busy(cmp_busy), .rep_busy(rep_busy), .done(done), .repair_ok(repair_ok),
      .cnt_12(cnt_12), .cnt_13(cnt_13), .cnt_23(cnt_23)
   );

   // behavioural scan chains: bit 0 is the scan-out end
   function automatic logic [L-1:0] chain_next(input logic [L-1:0] cur, input logic [L-1:0] flip,
                                               input logic en, input logic sin);
      logic [L-1:0] t;
      t = cur ^ flip;
      if (en) t = {sin, t[L-1:1]};
      return t;
   endfunction

   always @(posedge clk) begin
      for (int m = 0; m < 3; m++) begin
         if (ld) ch[m] <= ld_val[m];
         else    ch[m] <= chain_next(ch[m], inj[m], scan_en, scan_in[m]);
      end
   end
   assign scan_out = {ch[2][0], ch[1][0], ch[0][0]};

   task automatic check(input bit cond, input string req, input string what, input int act, input int exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   // monitor: every done pulse is matched against the next scoreboard entry
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(0, "R5", "unexpected done pulse", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(cnt_12) == e.c12, e.is_rep ? "R6" : "R2", {e.tag, " cnt_12"}, int'(cnt_12), e.c12);
            check(int'(cnt_13) == e.c13, e.is_rep ? "R6" : "R2", {e.tag, " cnt_13"}, int'(cnt_13), e.c13);
            check(int'(cnt_23) == e.c23, e.is_rep ? "R6" : "R2", {e.tag, " cnt_23"}, int'(cnt_23), e.c23);
            check(rep_busy == 1'b0, "R4", {e.tag, " rep_busy in done"}, int'(rep_busy), 0);
            check(repair_ok == e.ok, "R7", {e.tag, " repair_ok"}, int'(repair_ok), int'(e.ok));
         end
      end
   end

   function automatic int sat_cnt(input logic [L-1:0] d);
      int n;
      n = $countones(d);
      return (n > CMAX) ? CMAX : n;
   endfunction

   function automatic int floor_sub(input int a, input logic [L-1:0] d);
      int r;
      r = a - $countones(d);
      return (r < 0) ? 0 : r;
   endfunction

   function automatic int good_src(input logic [2:0] fm);
      if (!fm[0]) return 0;
      if (!fm[1]) return 1;
      return 2;
   endfunction

   // driver: load states, push expectations, run one compare (+ optional repair) pass
   task automatic run_case(input logic [L-1:0] e1, input logic [L-1:0] e2, input logic [L-1:0] e3,
                           input logic [2:0] fm, input bit restart, input bit inj_en, input string tag);
      logic [2:0][L-1:0] s, r, fin;
      exp_t ec, er;
      bit   do_rep;
      int   n, src;
      s[0] = GOLD ^ e1; s[1] = GOLD ^ e2; s[2] = GOLD ^ e3;
      do_rep = ($countones(fm) == 1) || ($countones(fm) == 2);
      ec.is_rep = 0; ec.tag = {tag, " compare"}; ec.ok = 0;
      ec.c12 = sat_cnt(s[0] ^ s[1]); ec.c13 = sat_cnt(s[0] ^ s[2]); ec.c23 = sat_cnt(s[1] ^ s[2]);
      r = s;
      if (inj_en) r[2][L-1] = ~r[2][L-1];
      er.is_rep = 1; er.tag = {tag, " repair"};
      er.c12 = floor_sub(ec.c12, r[0] ^ r[1]);
      er.c13 = floor_sub(ec.c13, r[0] ^ r[2]);
      er.c23 = floor_sub(ec.c23, r[1] ^ r[2]);
      er.ok  = (er.c12 == 0) && (er.c13 == 0) && (er.c23 == 0);
      src = good_src(fm);
      for (int m = 0; m < 3; m++) fin[m] = do_rep ? (fm[m] ? r[src] : r[m]) : s[m];

      @(negedge clk); ld_val = s; ld = 1'b1;
      @(negedge clk); ld = 1'b0;
      sb.push_back(ec);
      if (do_rep) sb.push_back(er);
      fault_mask = fm; start = 1'b1;
      @(posedge clk);
      @(negedge clk); start = 1'b0;
      n = 0;
      forever begin
         @(posedge clk); n++;
         @(negedge clk);
         start = restart && (n == 3);
         if (n == 1) check(scan_en && cmp_busy, "R1", {tag, " scan_en in compare"}, int'(scan_en), 1);
         if (done || n > 4 * L) break;
      end
      start = 1'b0;
      check(n == L, "R1", {tag, " compare length"}, n, L);
      @(posedge clk);
      @(negedge clk);
      if (do_rep) begin
         check(rep_busy && scan_en, "R5", {tag, " repair entered"}, int'(rep_busy), 1);
         if (inj_en) inj[2][L-1] = 1'b1;
         n = 1;
         forever begin
            @(posedge clk); n++;
            @(negedge clk);
            inj = '0;
            if (done || n > 4 * L) break;
         end
         check(n == L + 1, "R5", {tag, " repair length"}, n, L + 1);
         @(posedge clk);
         @(negedge clk);
      end else begin
         check(!rep_busy && !scan_en && !done, "R5", {tag, " no repair"}, int'(rep_busy), 0);
      end
      for (int m = 0; m < 3; m++)
         check(ch[m] == fin[m], do_rep ? "R5" : "R1", {tag, " chain state"}, int'(ch[m]), int'(fin[m]));
      check(!cmp_busy && !rep_busy && !repair_ok, "R7", {tag, " back to idle"}, int'(cmp_busy | rep_busy), 0);
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R7", {tag, " all done pulses seen"}, sb.size(), 0);
   endtask

   initial begin
      inj = '0;
      ld_val = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check(!scan_en && !cmp_busy && !rep_busy && !done && !repair_ok, "R8", "reset flags", int'(scan_en), 0);
      check(cnt_12 == 0 && cnt_13 == 0 && cnt_23 == 0, "R8", "reset counts", int'(cnt_12), 0);
      // R1 clean run, mask clear: no repair, states preserved
      run_case('0, '0, '0, 3'b000, 0, 0, "clean");
      // R2 R5 R6 single faulty module 2, with a start pulse during compare (R1)
      run_case('0, 16'h0109, '0, 3'b010, 1, 0, "single m2");
      // R5 two faulty, disjoint errors; source is module 3
      run_case(16'h0030, 16'h8402, '0, 3'b011, 0, 0, "two disjoint");
      // R2 two faulty sharing one erroneous bit
      run_case(16'h0011, 16'h0090, '0, 3'b011, 0, 0, "two common");
      // R3 saturation: module 1 fully inverted
      run_case(16'hFFFF, '0, '0, 3'b001, 0, 0, "saturate");
      // R5 mask with all three set: no repair pass
      run_case(16'h0001, 16'h0002, 16'h0004, 3'b111, 0, 0, "all faulty");
      // R7 upset during repair cancels one mismatch: repair_ok low
      run_case('0, '0, 16'h8004, 3'b100, 0, 1, "upset in repair");
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule